// File: doc/BRIEF.md
# Processor bus glue and address decode

This block sits between a 16-bit CPU with a multiplexed address/data bus and the memory and I/O devices around it. When the CPU pulls its address strobe low, the block captures the 22-bit physical address and the 4-bit access-type code. It keeps both until the next strobe, so it never decodes from the live bus. That matters because the same bus lines carry data once the address phase is over.

From the held address the block does three things:
- It splits memory into 32 blocks of 128 KB and brings out chip selects for the first six.
- It passes a word address to the RAM, starting from address bit 1.
- It decodes the top 8 KB of physical space as the I/O page. There it selects a boot ROM, a console serial port, a second serial port and a parallel port.

The access-type code and the data strobe set the write enables for the two byte lanes and the output enable for reads. All outputs are active high. The block has no data path and no streaming interface, so there is no back-pressure to manage.

Top module: `bus_glue`

## Requirements
- R1: Address and access code are captured on the clock edge at which `as_n` is first sampled low after being sampled high. They are held unchanged, whatever the bus does, until the next such edge.
- R2: While `rst_n` is low, and afterwards until the first capture, every chip select, write enable and the output enable are 0, and `ram_addr` is 0.
- R3: `ram_addr` equals held address bits 16:1. Held bit 0 never affects it.
- R4: `ram_cs[i]` is 1 exactly when held address bits 21:17 equal i (i = 0..5) and the address is outside the I/O page. Blocks 6 to 31 select no RAM.
- R5: The I/O page is every address whose bits 21:13 are all ones. Within it, `rom_cs` is 1 for 16-bit-view offsets octal 173000 to 173777 and nowhere else. The 16-bit view is octal 160000 plus address bits 12:0.
- R6: `con_cs` is 1 for I/O-page octal 177560 to 177567. `aux_cs` is 1 for I/O-page octal 176500 to 176507.
- R7: `par_cs` is 1 for I/O-page octal 176160 to 176167. At most one select of all the outputs is ever 1.
- R8: Access code 4'b0011 is a byte write. With the data strobe active it asserts exactly one lane: `we_lo` when held bit 0 is 0, `we_hi` when it is 1.
- R9: Access code 4'b0010 is a word write. With the data strobe active it asserts both `we_lo` and `we_hi`, whatever held bit 0 is.
- R10: Access codes with bit 3 set (4'b1000 to 4'b1111) are reads and assert `oe` while the data strobe is active. All other codes assert neither `oe` nor any write enable.
- R11: The data strobe is active in the cycle after an edge on which `ds_n` is sampled low. `oe`, `we_lo` and `we_hi` are 0 in the cycle after any edge on which `ds_n` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_ad | input | 22 | Multiplexed bus; carries the physical address while `as_n` falls |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 1 | Data strobe, active low |
| acc_code | input | 4 | Access-type code of the cycle |
| ram_addr | output | 16 | RAM word address (held address bits 16:1) |
| ram_cs | output | 6 | RAM block selects, one per 128 KB block |
| we_lo | output | 1 | Even (low) byte lane write enable |
| we_hi | output | 1 | Odd (high) byte lane write enable |
| oe | output | 1 | Output enable for reads |
| rom_cs | output | 1 | Boot ROM select |
| con_cs | output | 1 | Console serial port select |
| aux_cs | output | 1 | Second serial port select |
| par_cs | output | 1 | Parallel port select |

## Verification
The selects and `ram_addr` are due in the cycle right after the edge that first samples `as_n` low. `oe`, `we_lo` and `we_hi` follow `ds_n` one edge later, both when they rise and when they fall. The bench model is updated on the rising edge, from the same input values the design sees. Every output is then compared against the model on the following falling edge, so each result is checked exactly in the cycle it is due. The bus is driven to a different value during the data phase to show that the held address, not the live bus, drives the decode.

// File: rtl/bus_glue_pkg.sv
package bus_glue_pkg;
  localparam int CODE_W = 4;
  localparam logic [CODE_W-1:0] ACC_WORD_WR = 4'b0010;
  localparam logic [CODE_W-1:0] ACC_BYTE_WR = 4'b0011;
  localparam int READ_BIT = CODE_W - 1;

  localparam int N_IO_REGIONS = 4;
  localparam int IO_ROM = 0;
  localparam int IO_CON = 1;
  localparam int IO_AUX = 2;
  localparam int IO_PAR = 3;
endpackage

// File: rtl/bg_addr_capture.sv
module bg_addr_capture #(
  parameter int PA_W   = 22,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as_n,
  input  logic [PA_W-1:0]   bus_ad,
  input  logic [CODE_W-1:0] acc_code,
  output logic [PA_W-1:0]   cap_addr,
  output logic [CODE_W-1:0] cap_code,
  output logic              cap_valid
);
  logic as_q;
  logic as_fall;

  assign as_fall = as_q & ~as_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      as_q      <= 1'b1;
      cap_addr  <= '0;
      cap_code  <= '0;
      cap_valid <= 1'b0;
    end else begin
      as_q <= as_n;
      if (as_fall) begin
        cap_addr  <= bus_ad;
        cap_code  <= acc_code;
        cap_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bg_mem_decode.sv
module bg_mem_decode #(
  parameter int PA_W         = 22,
  parameter int BLK_BITS     = 5,
  parameter int RAM_BLKS     = 6,
  parameter int IOP_OFF_BITS = 13
) (
  input  logic [PA_W-1:1]          addr_hi,
  input  logic                     cap_valid,
  output logic [RAM_BLKS-1:0]      ram_cs,
  output logic [PA_W-BLK_BITS-2:0] ram_addr,
  output logic                     in_iopage
);
  localparam int BLK_LSB = PA_W - BLK_BITS;

  logic [BLK_BITS-1:0] blk;

  assign blk       = addr_hi[PA_W-1:BLK_LSB];
  assign in_iopage = &addr_hi[PA_W-1:IOP_OFF_BITS];
  assign ram_addr  = addr_hi[BLK_LSB-1:1];

  for (genvar i = 0; i < RAM_BLKS; i++) begin : g_blk
    assign ram_cs[i] = cap_valid & ~in_iopage & (blk == BLK_BITS'(i));
  end
endmodule

// File: rtl/bg_io_decode.sv
module bg_io_decode
  import bus_glue_pkg::*;
#(
  parameter int          IOP_OFF_BITS = 13,
  parameter logic [15:0] ROM_BASE     = 16'o173000,
  parameter logic [15:0] CON_BASE     = 16'o177560,
  parameter logic [15:0] AUX_BASE     = 16'o176500,
  parameter logic [15:0] PAR_BASE     = 16'o176160,
  parameter int          ROM_SPAN     = 9,
  parameter int          PORT_SPAN    = 3
) (
  input  logic [IOP_OFF_BITS-1:0] off,
  input  logic                    in_iopage,
  input  logic                    cap_valid,
  output logic [N_IO_REGIONS-1:0] io_cs
);
  localparam logic [15:0] BASE_TBL [N_IO_REGIONS] = '{ROM_BASE, CON_BASE, AUX_BASE, PAR_BASE};
  localparam int          SPAN_TBL [N_IO_REGIONS] = '{ROM_SPAN, PORT_SPAN, PORT_SPAN, PORT_SPAN};

  for (genvar r = 0; r < N_IO_REGIONS; r++) begin : g_region
    localparam logic [IOP_OFF_BITS-1:0] BASE_OFF = IOP_OFF_BITS'(BASE_TBL[r]);
    assign io_cs[r] = cap_valid & in_iopage &
                      ((off >> SPAN_TBL[r]) == (BASE_OFF >> SPAN_TBL[r]));
  end
endmodule

// File: rtl/bg_lane_ctrl.sv
module bg_lane_ctrl
  import bus_glue_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ds_n,
  input  logic [CODE_W-1:0] cap_code,
  input  logic              cap_a0,
  input  logic              cap_valid,
  output logic              we_lo,
  output logic              we_hi,
  output logic              oe
);
  logic ds_act;
  logic live;
  logic wr_word;
  logic wr_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) ds_act <= 1'b0;
    else        ds_act <= ~ds_n;
  end

  assign live    = cap_valid & ds_act;
  assign wr_word = (cap_code == ACC_WORD_WR);
  assign wr_byte = (cap_code == ACC_BYTE_WR);

  assign we_lo = live & (wr_word | (wr_byte & ~cap_a0));
  assign we_hi = live & (wr_word | (wr_byte &  cap_a0));
  assign oe    = live & cap_code[READ_BIT];
endmodule

// File: rtl/bus_glue.sv
module bus_glue
  import bus_glue_pkg::*;
#(
  parameter int PA_W         = 22,
  parameter int BLK_BITS     = 5,
  parameter int RAM_BLKS     = 6,
  parameter int IOP_OFF_BITS = 13,
  localparam int RAM_AW      = PA_W - BLK_BITS - 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PA_W-1:0]     bus_ad,
  input  logic                as_n,
  input  logic                ds_n,
  input  logic [CODE_W-1:0]   acc_code,
  output logic [RAM_AW-1:0]   ram_addr,
  output logic [RAM_BLKS-1:0] ram_cs,
  output logic                we_lo,
  output logic                we_hi,
  output logic                oe,
  output logic                rom_cs,
  output logic                con_cs,
  output logic                aux_cs,
  output logic                par_cs
);
  logic [PA_W-1:0]         cap_addr;
  logic [CODE_W-1:0]       cap_code;
  logic                    cap_valid;
  logic                    in_iopage;
  logic [N_IO_REGIONS-1:0] io_cs;

  bg_addr_capture #(.PA_W(PA_W), .CODE_W(CODE_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .bus_ad(bus_ad), .acc_code(acc_code),
    .cap_addr(cap_addr), .cap_code(cap_code), .cap_valid(cap_valid)
  );

  bg_mem_decode #(
    .PA_W(PA_W), .BLK_BITS(BLK_BITS), .RAM_BLKS(RAM_BLKS), .IOP_OFF_BITS(IOP_OFF_BITS)
  ) u_mem (
    .addr_hi(cap_addr[PA_W-1:1]), .cap_valid(cap_valid),
    .ram_cs(ram_cs), .ram_addr(ram_addr), .in_iopage(in_iopage)
  );

  bg_io_decode #(.IOP_OFF_BITS(IOP_OFF_BITS)) u_io (
    .off(cap_addr[IOP_OFF_BITS-1:0]), .in_iopage(in_iopage),
    .cap_valid(cap_valid), .io_cs(io_cs)
  );

  bg_lane_ctrl u_lane (
    .clk(clk), .rst_n(rst_n), .ds_n(ds_n), .cap_code(cap_code),
    .cap_a0(cap_addr[0]), .cap_valid(cap_valid),
    .we_lo(we_lo), .we_hi(we_hi), .oe(oe)
  );

  assign rom_cs = io_cs[IO_ROM];
  assign con_cs = io_cs[IO_CON];
  assign aux_cs = io_cs[IO_AUX];
  assign par_cs = io_cs[IO_PAR];
endmodule

// File: rtl/bus_glue_chk.sv
module bus_glue_chk #(
  parameter int RAM_AW   = 16,
  parameter int RAM_BLKS = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                as_n,
  input logic                ds_n,
  input logic [RAM_AW-1:0]   ram_addr,
  input logic [RAM_BLKS-1:0] ram_cs,
  input logic                we_lo,
  input logic                we_hi,
  input logic                oe,
  input logic                rom_cs,
  input logic                con_cs,
  input logic                aux_cs,
  input logic                par_cs,
  input logic [3:0]          cap_code,
  input logic                cap_valid,
  input logic                in_iopage
);
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (as_n || !$past(as_n)) |=> $stable(ram_addr)); // R1

  AST_IOPAGE_NO_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && in_iopage) |-> (ram_cs == '0)); // R4

  AST_SINGLE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ram_cs, rom_cs, con_cs, aux_cs, par_cs}) <= 1); // R7

  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && cap_code == 4'b0011 && !$past(ds_n)) |-> ($countones({we_hi, we_lo}) == 1)); // R8

  AST_WORD_BOTH_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && cap_code == 4'b0010 && !$past(ds_n)) |-> (we_lo && we_hi)); // R9

  AST_STROBE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (we_lo || we_hi || oe) |-> !$past(ds_n)); // R11
endmodule

bind bus_glue bus_glue_chk #(.RAM_AW(RAM_AW), .RAM_BLKS(RAM_BLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .as_n(as_n), .ds_n(ds_n),
  .ram_addr(ram_addr), .ram_cs(ram_cs), .we_lo(we_lo), .we_hi(we_hi), .oe(oe),
  .rom_cs(rom_cs), .con_cs(con_cs), .aux_cs(aux_cs), .par_cs(par_cs),
  .cap_code(cap_code), .cap_valid(cap_valid), .in_iopage(in_iopage)
);

// File: tb/sim_bus_glue.sv
`timescale 1ns/1ps
module sim_bus_glue;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [21:0] bus_ad = '0;
  logic        as_n = 1'b1;
  logic        ds_n = 1'b1;
  logic [3:0]  acc_code = '0;
  logic [15:0] ram_addr;
  logic [5:0]  ram_cs;
  logic        we_lo, we_hi, oe, rom_cs, con_cs, aux_cs, par_cs;

  int checks = 0;
  int bad = 0;

  always #5 clk = ~clk;

  bus_glue u0 (
    .clk(clk), .rst_n(rst_n), .bus_ad(bus_ad), .as_n(as_n), .ds_n(ds_n),
    .acc_code(acc_code), .ram_addr(ram_addr), .ram_cs(ram_cs),
    .we_lo(we_lo), .we_hi(we_hi), .oe(oe), .rom_cs(rom_cs),
    .con_cs(con_cs), .aux_cs(aux_cs), .par_cs(par_cs)
  );

  // behavioural reference state
  int m_addr = 0;
  int m_code = 0;
  bit m_valid = 0;
  bit m_ds = 0;
  bit m_prev_as = 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_addr = 0; m_code = 0; m_valid = 0; m_ds = 0; m_prev_as = 1;
    end else begin
      if (m_prev_as && !as_n) begin
        m_addr = int'(bus_ad); m_code = int'(acc_code); m_valid = 1;
      end
      m_prev_as = as_n;
      m_ds = !ds_n;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%0h expected=%0h (addr=%0h code=%0h)", tag, got, exp, m_addr, m_code);
    end
  endtask

  function automatic bit in_rng(input int v, input int lo, input int hi);
    return (v >= lo) && (v <= hi);
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R2 reset outputs",
          int'({ram_cs, we_lo, we_hi, oe, rom_cs, con_cs, aux_cs, par_cs}), 0);
      chk("R2 reset ram_addr", int'(ram_addr), 0);
    end else begin
      bit iop;
      int blk, v, exp_cs;
      bit e_lo, e_hi, e_oe, live;
      iop = m_valid && ((m_addr >> 13) == 'h1FF);
      blk = m_addr >> 17;
      v = 'o160000 + (m_addr % 8192);
      exp_cs = (m_valid && !iop && blk < 6) ? (1 << blk) : 0;
      live = m_valid && m_ds;
      e_lo = live && (m_code == 2 || (m_code == 3 && (m_addr % 2) == 0));
      e_hi = live && (m_code == 2 || (m_code == 3 && (m_addr % 2) == 1));
      e_oe = live && (m_code >= 8);
      chk("R1/R3 ram_addr", int'(ram_addr), (m_addr / 2) % 65536);
      chk("R4 ram_cs", int'(ram_cs), exp_cs);
      chk("R5 rom_cs", int'(rom_cs), int'(iop && in_rng(v, 'o173000, 'o173777)));
      chk("R6 con_cs", int'(con_cs), int'(iop && in_rng(v, 'o177560, 'o177567)));
      chk("R6 aux_cs", int'(aux_cs), int'(iop && in_rng(v, 'o176500, 'o176507)));
      chk("R7 par_cs", int'(par_cs), int'(iop && in_rng(v, 'o176160, 'o176167)));
      if (m_code == 3)      chk("R8 byte lanes", int'({we_hi, we_lo}), int'({e_hi, e_lo}));
      else if (m_code == 2) chk("R9 word lanes", int'({we_hi, we_lo}), int'({e_hi, e_lo}));
      else                  chk("R10 no write on other code", int'({we_hi, we_lo}), int'({e_hi, e_lo}));
      chk("R10 oe", int'(oe), int'(e_oe));
      if (!m_ds) chk("R11 strobe idle", int'({we_hi, we_lo, oe}), 0);
    end
  end

  function automatic logic [21:0] iop_addr(input int octal16);
    return 22'h3FE000 + 22'(octal16 - 'o160000);
  endfunction

  task automatic cycle(input logic [21:0] a, input logic [3:0] code, input int ds_len);
    @(negedge clk); bus_ad = a; acc_code = code; as_n = 1'b1; ds_n = 1'b1;
    @(negedge clk); as_n = 1'b0;
    @(negedge clk); bus_ad = ~a; acc_code = ~code;
    @(negedge clk); ds_n = 1'b0;
    repeat (ds_len) @(negedge clk);
    ds_n = 1'b1;
    @(negedge clk); as_n = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog: got=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R2: outputs quiet before any capture
    chk("R2 idle before capture", int'({ram_cs, we_lo, we_hi, oe, rom_cs}), 0);
    // R4, R10: reads across RAM blocks and beyond
    for (int b = 0; b < 8; b++) cycle(22'((b << 17) | 'h1234), 4'b1001, 2);
    cycle(22'h3E0010, 4'b1000, 1);
    // R5..R7: I/O page regions and their edges
    cycle(iop_addr('o173000), 4'b1100, 1);
    cycle(iop_addr('o173777), 4'b1100, 1);
    cycle(iop_addr('o174000), 4'b1100, 1);
    cycle(iop_addr('o172776), 4'b1100, 1);
    cycle(iop_addr('o177560), 4'b1010, 1);
    cycle(iop_addr('o177567), 4'b0010, 1);
    cycle(iop_addr('o177570), 4'b1010, 1);
    cycle(iop_addr('o176500), 4'b1010, 1);
    cycle(iop_addr('o176510), 4'b1010, 1);
    cycle(iop_addr('o176160), 4'b0011, 1);
    cycle(iop_addr('o176166), 4'b1010, 1);
    cycle(iop_addr('o176170), 4'b1010, 1);
    // ROM offset outside the I/O page must not select the ROM (R5)
    cycle(22'h001600, 4'b1000, 1);
    // R8: byte writes, even and odd
    cycle(22'h012344, 4'b0011, 2);
    cycle(22'h012345, 4'b0011, 2);
    cycle(22'h0A0001, 4'b0011, 3);
    // R9: word writes with bit 0 both ways
    cycle(22'h054320, 4'b0010, 2);
    cycle(22'h054321, 4'b0010, 2);
    // R10: non-transfer codes
    cycle(22'h000100, 4'b0000, 2);
    cycle(22'h000101, 4'b0111, 2);
    // R1: back-to-back strobes with minimal gaps
    for (int k = 0; k < 6; k++) cycle(22'(k * 'h5A5A1), 4'(k * 5), 1 + k % 3);
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule